// File: doc/BRIEF.md
# Identity Comparator Built from Lookup Tables and a Carry Chain

This block decides whether two operand vectors of a parameterized width are identical, and reports either "equal" or "different" depending on a mode fixed at compile time. It is built structurally: small lookup-table cells, each described by a truth-table constant, and 2:1 carry multiplexers. This mirrors how a programmable fabric would implement the compare.

Operands of one or two bits fit in a single lookup table. The mode is encoded directly in that table's constant. Wider operands are split into stages of two bit pairs. Every stage table answers "these bits match". That answer steers a carry multiplexer. A matching stage passes the carry from below. A mismatching stage injects a fixed constant. The inequality mode reuses the same equality tables. It swaps the constant injected by mismatching stages with the constant fed into the bottom of the chain, so the result comes out inverted with no extra gate on the output.

Top module: `ident_compare`

## Requirements
- R1: With MODE = CMP_EQ, `result` is 1 exactly when every bit of `op_a` equals the matching bit of `op_b`, for any WIDTH of 1 or more.
- R2: With MODE = CMP_NE, `result` is 1 exactly when at least one bit position of `op_a` and `op_b` differs.
- R3: WIDTH = 1 uses one 2-input table indexed by {B,A}. Its constant is 4'h9 for CMP_EQ and 4'h6 for CMP_NE.
- R4: WIDTH = 2 uses one 4-input table indexed by {B[1],A[1],B[0],A[0]}. Its constant is 16'h9009 for CMP_EQ and 16'h6FF6 for CMP_NE.
- R5: For WIDTH of 3 or more there are ceil(WIDTH/2) stages. Stage k compares bits 2k and 2k+1 with a 4-input equality table (16'h9009). When WIDTH is odd, the top stage compares only the last bit with a 2-input equality table (4'h9). These tables are the same in both modes.
- R6: In CMP_EQ mode, mismatching stages inject 0 and the chain starts from 1. The carry above stage k is 1 exactly when all bits from 0 through 2k+1 match, so a mismatch at any position, lowest or highest, clears the result.
- R7: In CMP_NE mode, mismatching stages inject 1 and the chain starts from 0. The carry above stage k is 1 exactly when some bit from 0 through 2k+1 differs.
- R8: The block is purely combinational. `result` follows the operands with no clock cycle of delay, including while the surrounding system is held in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| result | output | 1 | Equality or inequality outcome, selected by MODE |

## Verification
Every result is due in the same cycle as its operands, because there is no register between the operand ports and `result`. The bench changes operands just after a rising edge and samples `result` at the following falling edge. That leaves half a period for the chain to settle and keeps stimulus and sampling apart from any clock edge. Eighteen instances, covering widths 1 to 9 in both modes, share the same operand drivers. Each is checked against a mask-and-compare reference in every cycle. Exhaustive 7-bit sweeps are followed by walking single-bit mismatches and random 9-bit patterns.

// File: rtl/idcmp_pkg.sv
package idcmp_pkg;

   typedef enum logic {
      CMP_EQ = 1'b0,
      CMP_NE = 1'b1
   } cmp_mode_e;

   // Truth tables, index = {I3,I2,I1,I0} or {I1,I0}
   localparam logic [3:0]  TT2_SAME = 4'h9;
   localparam logic [3:0]  TT2_DIFF = 4'h6;
   localparam logic [15:0] TT4_SAME = 16'h9009;
   localparam logic [15:0] TT4_DIFF = 16'h6FF6;

endpackage

// File: rtl/idcmp_lut.sv
module idcmp_lut #(
   parameter int unsigned N_IN = 2,
   parameter logic [(1 << N_IN) - 1:0] INIT = '0
) (
   input  logic [N_IN-1:0] sel_in,
   output logic            lut_o
);

   if (N_IN < 1 || N_IN > 6) begin : g_bad_nin
      $error("idcmp_lut: N_IN must be within 1..6");
   end

   assign lut_o = INIT[sel_in];

endmodule

// File: rtl/idcmp_cymux.sv
module idcmp_cymux (
   input  logic sel,
   input  logic ci,
   input  logic di,
   output logic co
);

   // select high: stage bits matched, pass lower carry upward
   assign co = sel ? ci : di;

endmodule

// File: rtl/ident_compare.sv
module ident_compare
   import idcmp_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter cmp_mode_e   MODE  = CMP_EQ
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic             result
);

   localparam int unsigned NSTG      = (WIDTH + 1) / 2;
   localparam bit          IS_EQ     = (MODE == CMP_EQ);
   localparam logic        CHAIN_DI  = IS_EQ ? 1'b0 : 1'b1;
   localparam logic        CHAIN_CI0 = IS_EQ ? 1'b1 : 1'b0;

   if (WIDTH < 1) begin : g_bad_width
      $error("ident_compare: WIDTH must be at least 1");
   end

   // chain_c[0] is the chain base, chain_c[k+1] the carry above stage k
   logic [NSTG:0] chain_c;

   if (WIDTH == 1) begin : g_single1
      logic lut_o;
      idcmp_lut #(
         .N_IN (2),
         .INIT (IS_EQ ? TT2_SAME : TT2_DIFF)
      ) u_lut (
         .sel_in ({op_b[0], op_a[0]}),
         .lut_o  (lut_o)
      );
      assign chain_c = {lut_o, CHAIN_CI0};
   end else if (WIDTH == 2) begin : g_single2
      logic lut_o;
      idcmp_lut #(
         .N_IN (4),
         .INIT (IS_EQ ? TT4_SAME : TT4_DIFF)
      ) u_lut (
         .sel_in ({op_b[1], op_a[1], op_b[0], op_a[0]}),
         .lut_o  (lut_o)
      );
      assign chain_c = {lut_o, CHAIN_CI0};
   end else begin : g_chain
      logic [NSTG-1:0] stg_match;
      assign chain_c[0] = CHAIN_CI0;
      for (genvar k = 0; k < NSTG; k++) begin : g_stg
         if (2 * k + 1 < WIDTH) begin : g_pair
            idcmp_lut #(
               .N_IN (4),
               .INIT (TT4_SAME)
            ) u_lut (
               .sel_in ({op_b[2*k+1], op_a[2*k+1], op_b[2*k], op_a[2*k]}),
               .lut_o  (stg_match[k])
            );
         end else begin : g_tail1
            idcmp_lut #(
               .N_IN (2),
               .INIT (TT2_SAME)
            ) u_lut (
               .sel_in ({op_b[2*k], op_a[2*k]}),
               .lut_o  (stg_match[k])
            );
         end
         idcmp_cymux u_mux (
            .sel (stg_match[k]),
            .ci  (chain_c[k]),
            .di  (CHAIN_DI),
            .co  (chain_c[k+1])
         );
      end
   end

   assign result = chain_c[NSTG];

endmodule

// File: rtl/ident_compare_chk.sv
module ident_compare_chk
   import idcmp_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter cmp_mode_e   MODE  = CMP_EQ
) (
   input logic [WIDTH-1:0]           op_a,
   input logic [WIDTH-1:0]           op_b,
   input logic                       result,
   input logic [(WIDTH + 1) / 2:0]   chain_c
);

   localparam int unsigned NSTG = (WIDTH + 1) / 2;

   function automatic logic [WIDTH-1:0] low_mask(input int unsigned k);
      logic [WIDTH-1:0] m;
      for (int unsigned i = 0; i < WIDTH; i++) begin
         m[i] = (i <= 2 * k + 1);
      end
      return m;
   endfunction

   logic [WIDTH-1:0] diff_v;
   assign diff_v = op_a ^ op_b;

   always_comb begin
      if (MODE == CMP_EQ) begin
         AST_EQ_RESULT: assert (result == (op_a == op_b)); // R1
      end else begin
         AST_NE_RESULT: assert (result == (op_a != op_b)); // R2
      end
      for (int unsigned k = 0; k < NSTG; k++) begin
         if (MODE == CMP_EQ) begin
            AST_EQ_PREFIX: assert (chain_c[k+1] == ((diff_v & low_mask(k)) == '0)); // R6
         end else begin
            AST_NE_PREFIX: assert (chain_c[k+1] == ((diff_v & low_mask(k)) != '0)); // R7
         end
      end
   end

endmodule

bind ident_compare ident_compare_chk #(
   .WIDTH (WIDTH),
   .MODE  (MODE)
) u_chk (
   .op_a    (op_a),
   .op_b    (op_b),
   .result  (result),
   .chain_c (chain_c)
);

// File: tb/ident_compare_tb_top.sv
`timescale 1ns/1ps
module ident_compare_tb_top;
   import idcmp_pkg::*;

   localparam int MAXW   = 9;
   localparam int WD_CYC = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [MAXW-1:0] a_drv = '0;
   logic [MAXW-1:0] b_drv = '0;
   logic res_q [1:MAXW][0:1];

   int n_checks = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   for (genvar w = 1; w <= MAXW; w++) begin : g_w
      for (genvar m = 0; m < 2; m++) begin : g_m
         ident_compare #(
            .WIDTH (w),
            .MODE  (m == 0 ? CMP_EQ : CMP_NE)
         ) dut_i (
            .op_a   (a_drv[w-1:0]),
            .op_b   (b_drv[w-1:0]),
            .result (res_q[w][m])
         );
      end
   end

   task automatic check_all(input string note);
      for (int w = 1; w <= MAXW; w++) begin
         for (int m = 0; m < 2; m++) begin
            logic [MAXW-1:0] mask;
            logic same;
            logic exp;
            string tag;
            mask = MAXW'((1 << w) - 1);
            same = ((a_drv ^ b_drv) & mask) == '0;
            exp = (m == 0) ? same : !same;
            tag = {(m == 0) ? "R1" : "R2", " ",
                   (w == 1) ? "R3" : (w == 2) ? "R4" : "R5", " ", note};
            n_checks++;
            if (res_q[w][m] !== exp) begin
               n_err++;
               $display("FAIL %s width=%0d a=%h b=%h actual=%0b expected=%0b",
                        tag, w, a_drv, b_drv, res_q[w][m], exp);
            end
         end
      end
   endtask

   task automatic apply(input logic [MAXW-1:0] a, input logic [MAXW-1:0] b,
                        input string note);
      @(posedge clk);
      #1;
      a_drv = a;
      b_drv = b;
      @(negedge clk);
      check_all(note);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (2) @(negedge clk);
      check_all("R8 reset");
      @(posedge clk);
      #1 rst_n = 1'b1;

      // exhaustive sweep over the low 7 bits of both operands
      for (int i = 0; i < 16384; i++) begin
         apply(MAXW'(i[6:0]), MAXW'(i[13:7]), "R8 exhaustive");
      end

      // walking single-bit mismatch, including LSB and MSB
      for (int r = 0; r < 40; r++) begin
         logic [MAXW-1:0] base;
         base = MAXW'($urandom);
         apply(base, base, "R6 R7 identical");
         for (int j = 0; j < MAXW; j++) begin
            apply(base, base ^ (MAXW'(1) << j), "R6 R7 single-bit mismatch");
         end
      end

      // random wide patterns, biased toward equal operands
      for (int r = 0; r < 3000; r++) begin
         logic [MAXW-1:0] av;
         logic [MAXW-1:0] bv;
         int sel;
         av = MAXW'($urandom);
         sel = int'($urandom % 3);
         if (sel == 0) bv = av;
         else if (sel == 1) bv = av ^ (MAXW'(1) << ($urandom % MAXW));
         else bv = MAXW'($urandom);
         apply(av, bv, "R6 R7 random");
      end

      finish_run();
   end

   initial begin
      #(WD_CYC * 20);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog R8 actual=timeout expected=completion");
         finish_run();
      end
   end

endmodule